// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block is a clocked flag controller. It sits next to a two-port byte memory and lets the two ports signal each other. Each port has one mailbox location at the top of the address space. The left port owns the second-highest address and the right port owns the highest. When one port writes into its partner's mailbox, the controller raises the partner's interrupt flag. When the partner then accesses that mailbox with its output enable active, the flag drops again.

A busy indication from either port stops that port's access from changing a flag. If a flag is set and cleared in the same cycle, the set wins, so a new message is never lost. The message byte stays in the memory array, which is outside this block. The two mailbox addresses remain ordinary storage whether or not a port watches its flag.

The controller samples the port controls on each rising clock edge and drives registered, active-low flag outputs.

Top module: `dpmb_irq_flags`

## Requirements
- R1: While `rst` is high, and on the first edge after reset, both `left_irq_n` and `right_irq_n` are 1.
- R2: A right-port write with `right_ce_n`=0, `right_rw_n`=0, `right_addr`=0x7FE and `right_busy_n`=1 drives `left_irq_n` to 0 one clock after the sampling edge.
- R3: A left-port access with `left_ce_n`=0, `left_oe_n`=0, `left_addr`=0x7FE and `left_busy_n`=1 returns `left_irq_n` to 1 one clock later, whatever the value of `left_rw_n`.
- R4: A left-port write with `left_ce_n`=0, `left_rw_n`=0, `left_addr`=0x7FF and `left_busy_n`=1 drives `right_irq_n` to 0 one clock later.
- R5: A right-port access with `right_ce_n`=0, `right_oe_n`=0, `right_addr`=0x7FF and `right_busy_n`=1 returns `right_irq_n` to 1 one clock later, whatever the value of `right_rw_n`.
- R6: A write into the partner's mailbox while the writing port's busy input is 0 leaves the partner's flag unchanged.
- R7: A mailbox access that would otherwise clear a flag leaves that flag unchanged while the clearing port's busy input is 0.
- R8: When a set and a clear of the same flag fall in one cycle, the flag ends up asserted (0).
- R9: All other activity leaves both flags unchanged. This includes a port writing its own mailbox, a port with chip enable high, a mailbox access with output enable high, and accesses to any non-mailbox address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| left_ce_n | input | 1 | Left port chip enable, active low |
| left_rw_n | input | 1 | Left port read/write, 0 = write |
| left_oe_n | input | 1 | Left port output enable, active low |
| left_addr | input | 11 | Left port byte address |
| left_busy_n | input | 1 | Left port busy indication, 0 = busy |
| right_ce_n | input | 1 | Right port chip enable, active low |
| right_rw_n | input | 1 | Right port read/write, 0 = write |
| right_oe_n | input | 1 | Right port output enable, active low |
| right_addr | input | 11 | Right port byte address |
| right_busy_n | input | 1 | Right port busy indication, 0 = busy |
| left_irq_n | output | 1 | Interrupt flag toward the left port, active low |
| right_irq_n | output | 1 | Interrupt flag toward the right port, active low |

## Verification
A flag set or clear is due exactly one rising edge after the cycle in which the qualifying access is presented. Reset takes effect on the same edge that samples it. The bench applies each stimulus at a falling edge and waits for the following rising edge. It then compares both flags at the next falling edge, before new inputs are applied. As a result, every expected value reflects exactly one register update. Because both flags are checked after every step, each vector also confirms that the flag it did not target stayed where it was.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

    // Which side of the two-port memory a piece of logic serves
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;

    // Port controls after conversion to active-high meaning
    typedef struct packed {
        logic sel;    // chip enabled
        logic wr;     // write cycle
        logic oe;     // output enable active
        logic free;   // busy not asserted
    } port_ctl_t;

    function automatic port_ctl_t decode_ctl(
        input logic ce_n,
        input logic rw_n,
        input logic oe_n,
        input logic busy_n
    );
        port_ctl_t c;
        c.sel  = ~ce_n;
        c.wr   = ~rw_n;
        c.oe   = ~oe_n;
        c.free = busy_n;
        return c;
    endfunction

    // Pending-flag update: a set beats a simultaneous clear
    function automatic logic flag_next(
        input logic pend,
        input logic set,
        input logic clr
    );
        return set | (pend & ~clr);
    endfunction

    function automatic side_e peer_of(input side_e s);
        return (s == SIDE_LEFT) ? SIDE_RIGHT : SIDE_LEFT;
    endfunction

endpackage

// File: rtl/dpmb_port_decode.sv
module dpmb_port_decode
    import dpmb_pkg::*;
#(
    parameter int    ADDR_W = 11,
    parameter side_e SIDE   = SIDE_LEFT
) (
    input  logic              ce_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic              set_peer,
    output logic              clr_own
);

    localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
    localparam logic [ADDR_W-1:0] LEFT_BOX  = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] RIGHT_BOX = TOP_ADDR;
    localparam logic [ADDR_W-1:0] OWN_BOX   = (SIDE == SIDE_LEFT) ? LEFT_BOX  : RIGHT_BOX;
    localparam logic [ADDR_W-1:0] PEER_BOX  = (SIDE == SIDE_LEFT) ? RIGHT_BOX : LEFT_BOX;

    port_ctl_t ctl;

    always_comb begin
        ctl      = decode_ctl(ce_n, rw_n, oe_n, busy_n);
        // writing the partner's mailbox raises the partner's flag
        set_peer = ctl.sel & ctl.wr & ctl.free & (addr == PEER_BOX);
        // own mailbox with output enable acknowledges; write strobe ignored
        clr_own  = ctl.sel & ctl.oe & ctl.free & (addr == OWN_BOX);
    end

endmodule

// File: rtl/dpmb_flag_reg.sv
module dpmb_flag_reg
    import dpmb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= flag_next(pend_q, set, clr);
        end
    end

    assign irq_n = ~pend_q;

endmodule

// File: rtl/dpmb_irq_flags.sv
module dpmb_irq_flags
    import dpmb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              left_ce_n,
    input  logic              left_rw_n,
    input  logic              left_oe_n,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              left_busy_n,
    input  logic              right_ce_n,
    input  logic              right_rw_n,
    input  logic              right_oe_n,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic              right_busy_n,
    output logic              left_irq_n,
    output logic              right_irq_n
);

    logic              ce_n   [NUM_SIDES];
    logic              rw_n   [NUM_SIDES];
    logic              oe_n   [NUM_SIDES];
    logic [ADDR_W-1:0] addr   [NUM_SIDES];
    logic              busy_n [NUM_SIDES];
    logic              set_peer [NUM_SIDES];
    logic              clr_own  [NUM_SIDES];
    logic              irq_n    [NUM_SIDES];

    assign ce_n[SIDE_LEFT]    = left_ce_n;
    assign rw_n[SIDE_LEFT]    = left_rw_n;
    assign oe_n[SIDE_LEFT]    = left_oe_n;
    assign addr[SIDE_LEFT]    = left_addr;
    assign busy_n[SIDE_LEFT]  = left_busy_n;
    assign ce_n[SIDE_RIGHT]   = right_ce_n;
    assign rw_n[SIDE_RIGHT]   = right_rw_n;
    assign oe_n[SIDE_RIGHT]   = right_oe_n;
    assign addr[SIDE_RIGHT]   = right_addr;
    assign busy_n[SIDE_RIGHT] = right_busy_n;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam side_e THIS = side_e'(s);
        localparam side_e PEER = peer_of(THIS);

        dpmb_port_decode #(
            .ADDR_W (ADDR_W),
            .SIDE   (THIS)
        ) u_dec (
            .ce_n     (ce_n[s]),
            .rw_n     (rw_n[s]),
            .oe_n     (oe_n[s]),
            .addr     (addr[s]),
            .busy_n   (busy_n[s]),
            .set_peer (set_peer[s]),
            .clr_own  (clr_own[s])
        );

        // this side's flag is set by the peer and cleared by this side
        dpmb_flag_reg u_flag (
            .clk   (clk),
            .rst   (rst),
            .set   (set_peer[PEER]),
            .clr   (clr_own[s]),
            .irq_n (irq_n[s])
        );
    end

    assign left_irq_n  = irq_n[SIDE_LEFT];
    assign right_irq_n = irq_n[SIDE_RIGHT];

endmodule

// File: rtl/dpmb_irq_flags_chk.sv
module dpmb_irq_flags_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              left_ce_n,
    input logic              left_rw_n,
    input logic              left_oe_n,
    input logic [ADDR_W-1:0] left_addr,
    input logic              left_busy_n,
    input logic              right_ce_n,
    input logic              right_rw_n,
    input logic              right_oe_n,
    input logic [ADDR_W-1:0] right_addr,
    input logic              right_busy_n,
    input logic              left_irq_n,
    input logic              right_irq_n
);

    localparam logic [ADDR_W-1:0] HI_BOX = '1;
    localparam logic [ADDR_W-1:0] LO_BOX = HI_BOX - 1'b1;

    // raw access shapes, busy not yet considered
    logic r_wr_lo, l_acc_lo, l_wr_hi, r_acc_hi;
    assign r_wr_lo  = !right_ce_n && !right_rw_n && (right_addr == LO_BOX);
    assign l_acc_lo = !left_ce_n  && !left_oe_n  && (left_addr  == LO_BOX);
    assign l_wr_hi  = !left_ce_n  && !left_rw_n  && (left_addr  == HI_BOX);
    assign r_acc_hi = !right_ce_n && !right_oe_n && (right_addr == HI_BOX);

    logic set_l, clr_l, set_r, clr_r;
    assign set_l = r_wr_lo  && right_busy_n;
    assign clr_l = l_acc_lo && left_busy_n;
    assign set_r = l_wr_hi  && left_busy_n;
    assign clr_r = r_acc_hi && right_busy_n;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (left_irq_n && right_irq_n));

    assert_left_set_R2: assert property (@(posedge clk) disable iff (rst)
        set_l |=> !left_irq_n);

    assert_left_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_l && !set_l) |=> left_irq_n);

    assert_right_set_R4: assert property (@(posedge clk) disable iff (rst)
        set_r |=> !right_irq_n);

    assert_right_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_r && !set_r) |=> right_irq_n);

    assert_busy_blocks_set_R6: assert property (@(posedge clk) disable iff (rst)
        (r_wr_lo && !right_busy_n && !clr_l) |=> $stable(left_irq_n));

    assert_busy_blocks_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (r_acc_hi && !right_busy_n && !set_r) |=> $stable(right_irq_n));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (set_r && clr_r) |=> !right_irq_n);

    assert_left_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!set_l && !clr_l) |=> $stable(left_irq_n));

    assert_right_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!set_r && !clr_r) |=> $stable(right_irq_n));

endmodule

bind dpmb_irq_flags dpmb_irq_flags_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpmb_irq_flags_test.sv
`timescale 1ns/1ps
module dpmb_irq_flags_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        left_ce_n, left_rw_n, left_oe_n, left_busy_n;
    logic        right_ce_n, right_rw_n, right_oe_n, right_busy_n;
    logic [10:0] left_addr, right_addr;
    logic        left_irq_n, right_irq_n;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    dpmb_irq_flags #(.ADDR_W(11)) uut (.*);

    typedef struct packed {
        logic [7:0]  req;
        logic        lce, lrw, loe;
        logic [10:0] la;
        logic        lbn;
        logic        rce, rrw, roe;
        logic [10:0] ra;
        logic        rbn;
        logic        el, er;
    } vec_t;

    localparam int NV = 18;
    // fields: req | left ce rw oe addr busy_n | right ce rw oe addr busy_n | exp left_irq_n right_irq_n
    localparam vec_t VECS [NV] = '{
        '{9, 0,0,1,11'h7FE,1, 1,1,1,11'h000,1, 1,1},  // R9 left writes its own box
        '{6, 1,1,1,11'h000,1, 0,0,1,11'h7FE,0, 1,1},  // R6 right busy blocks set
        '{2, 1,1,1,11'h000,1, 0,0,1,11'h7FE,1, 0,1},  // R2 right sets left flag
        '{9, 1,1,1,11'h000,1, 1,1,1,11'h000,1, 0,1},  // R9 idle holds
        '{7, 0,1,0,11'h7FE,0, 1,1,1,11'h000,1, 0,1},  // R7 left busy blocks clear
        '{9, 0,1,1,11'h7FE,1, 1,1,1,11'h000,1, 0,1},  // R9 output enable high
        '{9, 0,1,0,11'h7FD,1, 1,1,1,11'h000,1, 0,1},  // R9 non-mailbox read
        '{3, 0,0,0,11'h7FE,1, 1,1,1,11'h000,1, 1,1},  // R3 clear with rw low
        '{4, 0,0,1,11'h7FF,1, 1,1,1,11'h000,1, 1,0},  // R4 left sets right flag
        '{9, 1,1,1,11'h000,1, 0,0,1,11'h7FF,1, 1,0},  // R9 right writes its own box
        '{9, 1,1,1,11'h000,1, 1,1,0,11'h7FF,1, 1,0},  // R9 chip enable high
        '{5, 1,1,1,11'h000,1, 0,1,0,11'h7FF,1, 1,1},  // R5 right clears
        '{6, 0,0,1,11'h7FF,0, 1,1,1,11'h000,1, 1,1},  // R6 left busy blocks set
        '{4, 0,0,1,11'h7FF,1, 0,0,1,11'h7FE,1, 0,0},  // R4 and R2 together
        '{8, 0,0,1,11'h7FF,1, 0,1,0,11'h7FF,1, 0,0},  // R8 right set vs clear
        '{8, 0,1,0,11'h7FE,1, 0,0,1,11'h7FE,1, 0,0},  // R8 left set vs clear
        '{7, 1,1,1,11'h000,1, 0,1,0,11'h7FF,0, 0,0},  // R7 right busy blocks clear
        '{3, 0,1,0,11'h7FE,1, 0,1,0,11'h7FF,1, 1,1}   // R3 and R5 together
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        left_ce_n  = 1'b1; left_rw_n  = 1'b1; left_oe_n  = 1'b1; left_addr  = '0; left_busy_n  = 1'b1;
        right_ce_n = 1'b1; right_rw_n = 1'b1; right_oe_n = 1'b1; right_addr = '0; right_busy_n = 1'b1;
    endtask

    task automatic apply(input vec_t v);
        left_ce_n  = v.lce; left_rw_n  = v.lrw; left_oe_n  = v.loe; left_addr  = v.la; left_busy_n  = v.lbn;
        right_ce_n = v.rce; right_rw_n = v.rrw; right_oe_n = v.roe; right_addr = v.ra; right_busy_n = v.rbn;
        @(posedge clk);
        @(negedge clk);
        check($sformatf("R%0d", v.req), "left_irq_n", left_irq_n, v.el);
        check($sformatf("R%0d", v.req), "right_irq_n", right_irq_n, v.er);
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "left_irq_n in reset", left_irq_n, 1'b1);
        check("R1", "right_irq_n in reset", right_irq_n, 1'b1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
        end

        // R1: reset drops flags that are pending
        apply('{4, 0,0,1,11'h7FF,1, 0,0,1,11'h7FE,1, 0,0});
        idle_inputs();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "left_irq_n after reset", left_irq_n, 1'b1);
        check("R1", "right_irq_n after reset", right_irq_n, 1'b1);
        // R2 and R4: a write presented during reset has no effect
        right_ce_n = 1'b0; right_rw_n = 1'b0; right_addr = 11'h7FE;
        @(posedge clk);
        @(negedge clk);
        check("R1", "left_irq_n write during reset", left_irq_n, 1'b1);
        idle_inputs();
        rst = 1'b0;
        // R9: flags stay clear when inputs are idle after reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", "left_irq_n idle after reset", left_irq_n, 1'b1);
        check("R9", "right_irq_n idle after reset", right_irq_n, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule